// File: doc/BRIEF.md
# GPIO Edge Interrupt Unit

This block watches a set of general-purpose input banks (two banks of 32 pins by default) and records every enabled edge on them. Each pin has two independent detectors: one for rising edges and one for falling edges, each gated by its own software enable mask. A detected edge sets a sticky per-pin status bit of the matching kind. The bit stays set until software writes a one to that pin's position in the bank's clear register.

All status bits of all banks, together with the pending flag of a dedicated external interrupt pin, are ORed into a single request line. That line drives the interrupt channel the GPIO pins share with the dedicated pin. Software reads the status registers to tell which pin raised the request. Pin inputs are asynchronous and pass through a two-flop synchronizer before any edge is detected.

Top module: `gpio_edge_irq`

## Requirements
- R1: While reset is asserted, and after it is released with all pins low, every enable and status register reads 0 and `irq_o` is low.
- R2: A low-to-high change on a pin whose rising-enable bit is set sets that pin's rising-status bit. The bit is visible after the third rising clock edge that follows the pin change, and not after the second.
- R3: A high-to-low change on a pin whose falling-enable bit is set sets that pin's falling-status bit, with the same three-edge latency.
- R4: An edge on a pin whose enable bit for that edge direction is clear sets no status bit.
- R5: A status bit stays set after the pin returns to its former level, until it is cleared.
- R6: Writing the clear register of a bank clears both the rising and the falling status bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their status.
- R7: When a clear write and a newly detected edge for the same pin meet at the same clock edge, the new edge's status bit is set.
- R8: `irq_o` is the OR of every status bit of every bank and of `ext3_flag_i`. It is high exactly when one of them is set.
- R9: The address is {bank, offset}, with the offset in the low 3 bits. Offset 0 is rising-enable, 1 is falling-enable, 2 is rising-status, 3 is falling-status, and 4 is clear. The clear register reads 0. Writes to the status offsets are ignored. Banks do not affect each other.
- R10: Enable registers read back the value last written and change only on a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PORTS*PORT_W | Asynchronous pin levels; bank b occupies bits [b*PORT_W +: PORT_W] |
| ext3_flag_i | input | 1 | Pending flag of the dedicated external interrupt pin sharing the channel |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | BANK_W+3 | Register address {bank, offset} |
| wdata_i | input | PORT_W | Write data |
| rdata_o | output | PORT_W | Read data for addr_i, combinational |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench checks the status register after the second and after the third clock edge that follow a pin change. A synchronizer that is one stage too short or too long shows up as a bit appearing one cycle early or late. It schedules a clear write to land on the same edge as a new falling edge on a pin with a pending rising status. A design that lets the clear win loses the falling request, and one that clears only one direction leaves the rising bit set. Edges on pins that are not enabled, clears with zero data, and writes to status offsets are each followed by a read-back. A design that sets, drops or overwrites status in those cases is caught there. Bank 1 traffic is checked against bank 0 status to catch address-decode aliasing.

// File: rtl/gpio_edge_irq_pkg.sv
package gpio_edge_irq_pkg;
   typedef enum logic [2:0] {
      OFS_RISE_EN   = 3'd0,
      OFS_FALL_EN   = 3'd1,
      OFS_RISE_STAT = 3'd2,
      OFS_FALL_STAT = 3'd3,
      OFS_CLEAR     = 3'd4
   } reg_ofs_e;
endpackage

// File: rtl/gpio_edge_irq_sync.sv
module gpio_edge_irq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_edge_irq_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_irq_bank.sv
module gpio_edge_irq_bank #(
   parameter int W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] pin_s_i,
   input  logic         rise_en_we_i,
   input  logic         fall_en_we_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] rise_en_o,
   output logic [W-1:0] fall_en_o,
   output logic [W-1:0] rise_stat_o,
   output logic [W-1:0] fall_stat_o
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise_hit, fall_hit, clr_mask;

   assign rise_hit = pin_s_i & ~prev_q & rise_en_o;
   assign fall_hit = ~pin_s_i & prev_q & fall_en_o;
   assign clr_mask = clr_we_i ? wdata_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q      <= '0;
         rise_en_o   <= '0;
         fall_en_o   <= '0;
         rise_stat_o <= '0;
         fall_stat_o <= '0;
      end else begin
         prev_q <= pin_s_i;
         if (rise_en_we_i) rise_en_o <= wdata_i;
         if (fall_en_we_i) fall_en_o <= wdata_i;
         // a fresh edge takes precedence over a simultaneous clear
         rise_stat_o <= (rise_stat_o & ~clr_mask) | rise_hit;
         fall_stat_o <= (fall_stat_o & ~clr_mask) | fall_hit;
      end
   end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
   import gpio_edge_irq_pkg::*;
#(
   parameter int NUM_PORTS   = 2,
   parameter int PORT_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int BANK_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int ADDR_W     = BANK_W + 3,
   localparam int ALL_W      = NUM_PORTS * PORT_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ALL_W-1:0]  pins_i,
   input  logic              ext3_flag_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [PORT_W-1:0] wdata_i,
   output logic [PORT_W-1:0] rdata_o,
   output logic              irq_o
);
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("gpio_edge_irq: NUM_PORTS must be at least 1");
   end
   if (PORT_W < 1) begin : g_bad_width
      $error("gpio_edge_irq: PORT_W must be at least 1");
   end

   logic [ALL_W-1:0] pins_s;
   logic [ALL_W-1:0] rise_en_all, fall_en_all, rise_stat_all, fall_stat_all;
   logic [BANK_W-1:0] bank_sel;
   reg_ofs_e          ofs_sel;

   assign bank_sel = addr_i[ADDR_W-1:3];
   assign ofs_sel  = reg_ofs_e'(addr_i[2:0]);

   gpio_edge_irq_sync #(.W(ALL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pins_i),
      .q_o    (pins_s)
   );

   for (genvar b = 0; b < NUM_PORTS; b++) begin : g_bank
      logic hit;
      assign hit = wr_en_i && (bank_sel == BANK_W'(b));

      gpio_edge_irq_bank #(.W(PORT_W)) u_bank (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .pin_s_i      (pins_s[b*PORT_W +: PORT_W]),
         .rise_en_we_i (hit && ofs_sel == OFS_RISE_EN),
         .fall_en_we_i (hit && ofs_sel == OFS_FALL_EN),
         .clr_we_i     (hit && ofs_sel == OFS_CLEAR),
         .wdata_i      (wdata_i),
         .rise_en_o    (rise_en_all[b*PORT_W +: PORT_W]),
         .fall_en_o    (fall_en_all[b*PORT_W +: PORT_W]),
         .rise_stat_o  (rise_stat_all[b*PORT_W +: PORT_W]),
         .fall_stat_o  (fall_stat_all[b*PORT_W +: PORT_W])
      );
   end

   always_comb begin
      rdata_o = '0;
      for (int b = 0; b < NUM_PORTS; b++) begin
         if (bank_sel == BANK_W'(b)) begin
            unique case (ofs_sel)
               OFS_RISE_EN:   rdata_o = rise_en_all[b*PORT_W +: PORT_W];
               OFS_FALL_EN:   rdata_o = fall_en_all[b*PORT_W +: PORT_W];
               OFS_RISE_STAT: rdata_o = rise_stat_all[b*PORT_W +: PORT_W];
               OFS_FALL_STAT: rdata_o = fall_stat_all[b*PORT_W +: PORT_W];
               default:       rdata_o = '0;
            endcase
         end
      end
   end

   assign irq_o = (|rise_stat_all) | (|fall_stat_all) | ext3_flag_i;
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
   parameter int W = 64
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         wr_en_i,
   input logic         irq_o,
   input logic [W-1:0] rise_en,
   input logic [W-1:0] fall_en,
   input logic [W-1:0] rise_st,
   input logic [W-1:0] fall_st
);
   assert_reset_clear_R1: assert property (@(posedge clk_i)
      !rst_ni |=> (rise_en == '0 && fall_en == '0 && rise_st == '0 && fall_st == '0));

   assert_rise_needs_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((rise_st & ~$past(rise_st) & ~$past(rise_en)) == '0));

   assert_fall_needs_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((fall_st & ~$past(fall_st) & ~$past(fall_en)) == '0));

   assert_status_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(wr_en_i) |-> ((($past(rise_st) & ~rise_st) == '0) && (($past(fall_st) & ~fall_st) == '0)));

   assert_irq_covers_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_st != '0 || fall_st != '0) |-> irq_o);

   assert_enable_by_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(wr_en_i) |-> ($stable(rise_en) && $stable(fall_en)));
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.W(NUM_PORTS * PORT_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .wr_en_i (wr_en_i),
   .irq_o   (irq_o),
   .rise_en (rise_en_all),
   .fall_en (fall_en_all),
   .rise_st (rise_stat_all),
   .fall_st (fall_stat_all)
);

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [63:0] pins_i = '0;
   logic        ext3_flag_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [3:0]  addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        irq_o;
   int total = 0;
   int bad = 0;

   always #5 clk_i = ~clk_i;

   gpio_edge_irq u_gpio_edge_irq (
      .clk_i(clk_i), .rst_ni(rst_ni), .pins_i(pins_i), .ext3_flag_i(ext3_flag_i),
      .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
   );

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk_i);
      @(negedge clk_i);
   endtask

   task automatic wr(logic bank, logic [2:0] ofs, logic [31:0] d);
      wr_en_i = 1'b1; addr_i = {bank, ofs}; wdata_i = d;
      @(posedge clk_i); @(negedge clk_i);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(string req, logic bank, logic [2:0] ofs, logic [31:0] exp);
      addr_i = {bank, ofs};
      #1 chk(req, rdata_o, exp);
   endtask

   task automatic t_reset;
      for (int b = 0; b < 2; b++)
         for (int o = 0; o < 5; o++) rd("R1 reset regs", b[0], o[2:0], 32'h0);
      chk("R1 reset irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_enables;
      wr(0, 3'd0, 32'h0000_0030);
      wr(0, 3'd1, 32'h0000_0020);
      wr(1, 3'd0, 32'h8000_0001);
      rd("R10 rise_en b0", 0, 3'd0, 32'h0000_0030);
      rd("R10 fall_en b0", 0, 3'd1, 32'h0000_0020);
      rd("R10 rise_en b1", 1, 3'd0, 32'h8000_0001);
      rd("R10 fall_en b1", 1, 3'd1, 32'h0);
      wr(0, 3'd2, 32'hFFFF_FFFF);
      wr(0, 3'd3, 32'hFFFF_FFFF);
      rd("R9 status write ignored r", 0, 3'd2, 32'h0);
      rd("R9 status write ignored f", 0, 3'd3, 32'h0);
      rd("R9 clear reads 0", 0, 3'd4, 32'h0);
   endtask

   task automatic t_rise;
      pins_i[4] = 1'b1; pins_i[6] = 1'b1;
      step(2);
      rd("R2 not yet after two edges", 0, 3'd2, 32'h0);
      step(1);
      rd("R2 rise set, R4 pin6 masked", 0, 3'd2, 32'h0000_0010);
      chk("R8 irq from rise", {31'b0, irq_o}, 32'h1);
      pins_i[4] = 1'b0;
      step(3);
      rd("R4 fall not enabled", 0, 3'd3, 32'h0);
      rd("R5 rise held", 0, 3'd2, 32'h0000_0010);
   endtask

   task automatic t_clear;
      wr(0, 3'd4, 32'h0);
      rd("R6 zero clear no effect", 0, 3'd2, 32'h0000_0010);
      wr(0, 3'd4, 32'h0000_0010);
      rd("R6 cleared", 0, 3'd2, 32'h0);
      chk("R8 irq low", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_both;
      pins_i[5] = 1'b1; step(3);
      rd("R2 pin5 rise", 0, 3'd2, 32'h0000_0020);
      pins_i[5] = 1'b0; step(3);
      rd("R3 pin5 fall", 0, 3'd3, 32'h0000_0020);
      wr(0, 3'd4, 32'h0000_0020);
      rd("R6 both cleared r", 0, 3'd2, 32'h0);
      rd("R6 both cleared f", 0, 3'd3, 32'h0);
   endtask

   task automatic t_race;
      pins_i[5] = 1'b1; step(3);
      rd("R2 pin5 rise again", 0, 3'd2, 32'h0000_0020);
      pins_i[5] = 1'b0; step(2);
      wr(0, 3'd4, 32'h0000_0020);
      rd("R7 rise cleared", 0, 3'd2, 32'h0);
      rd("R7 edge wins over clear", 0, 3'd3, 32'h0000_0020);
      wr(0, 3'd4, 32'h0000_0020);
      chk("R8 irq low after race", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_bank1;
      pins_i[63] = 1'b1; pins_i[32] = 1'b1; step(3);
      rd("R9 bank1 rise", 1, 3'd2, 32'h8000_0001);
      rd("R9 bank0 untouched", 0, 3'd2, 32'h0);
      chk("R8 irq bank1", {31'b0, irq_o}, 32'h1);
      wr(1, 3'd4, 32'h8000_0000);
      rd("R6 bank1 partial clear", 1, 3'd2, 32'h0000_0001);
      chk("R8 irq one bit left", {31'b0, irq_o}, 32'h1);
      wr(1, 3'd4, 32'h0000_0001);
      chk("R8 irq clear bank1", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_ext;
      ext3_flag_i = 1'b1;
      #1 chk("R8 irq from dedicated pin", {31'b0, irq_o}, 32'h1);
      ext3_flag_i = 1'b0;
      #1 chk("R8 irq idle", {31'b0, irq_o}, 32'h0);
   endtask

   initial begin
      step(3);
      t_reset();
      rst_ni = 1'b1;
      step(2);
      t_reset();
      t_enables();
      t_rise();
      t_clear();
      t_both();
      t_race();
      t_bank1();
      t_ext();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule